// File: doc/BRIEF.md
# FCFS Delayed Write Memory

This block is a small word-addressed storage array, arranged as lines of four words, that several fixed clients share for writes. Each client drives a valid bit with an address and a data word. On every cycle it gets back a single bit: 1 means OK, the write was accepted this cycle, and 0 means WAIT. Clients are served one at a time, strictly in the order they first asked. The client being served must keep presenting its request for a programmable number of cycles before the write is accepted.

A separate side port writes at once. It never joins the order and never waits. A combinational view port returns all four words of any line so that the contents can be checked.

The clients are numbered 0 (memory), 1 (instruction fetch) and 2 (cache), and bit i of every per-client vector belongs to client i. The latency comes from the `delay_cfg` input. The counter loads it at reset and again after each completion.

Top module: `fcfs_delay_mem`

## Requirements
- R1: While `rst` is high at a clock edge, every word is cleared to zero, the order is emptied and the wait counter loads `delay_cfg`. Right after reset the view port reads zero and no `req_ok` bit is set.
- R2: Address `a` selects line `a / 4`, word `a % 4`. `view_data[k*W +: W]` is word k of the line chosen by `view_line`.
- R3: When `side_valid` is high, `side_ok` is high in the same cycle and `side_data` is stored at `side_addr` at the next edge. This holds whatever the order holds and whatever wait remains.
- R4: A client that presents while it is not already queued is appended to the tail of the order. A client that is already queued is never added again. New clients arriving in the same cycle are appended in ascending client number.
- R5: `req_ok[i]` is 1 only when client i presents, is at the head, and the wait counter is zero. Otherwise it is 0 and the array is not changed by that client. At most one `req_ok` bit is set per cycle.
- R6: A client that presents into an empty order and keeps presenting sees `delay_cfg` WAIT cycles followed by one OK. With `delay_cfg` = 0 it gets OK in its first cycle.
- R7: At each edge with a non-empty order, a zero count retires the head and reloads `delay_cfg`, and a non-zero count decrements by one. With an empty order the count holds.
- R8: A client that presents for the first time in the cycle in which the head completes gets WAIT. Its own full delay starts only after that edge.
- R9: Contending clients complete strictly in the order of their first presentation, even when a later arrival has a lower client number.
- R10: A head whose count reaches zero while it is not presenting is retired without writing, and the next client moves up.
- R11: If the side port and a completing queued write target the same word in one cycle, the side port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| delay_cfg | input | DW | Wait cycles before a queued write is accepted |
| req_valid | input | NREQ | Per-client request present |
| req_addr | input | NREQ*AW | Per-client word address, client i at [i*AW +: AW] |
| req_data | input | NREQ*W | Per-client write data, client i at [i*W +: W] |
| req_ok | output | NREQ | Per-client OK (1) or WAIT (0) |
| side_valid | input | 1 | Immediate side write request |
| side_addr | input | AW | Side write word address |
| side_data | input | W | Side write data |
| side_ok | output | 1 | Side write accepted |
| view_line | input | LW | Line selected for viewing |
| view_data | output | 4*W | The four words of the viewed line |

## Verification
Several properties are checked on every cycle. At most one grant is given per cycle. The occupancy count stays consistent with the per-client queued flags and never exceeds the client count, which together guard against a duplicate entry. The wait counter steps down by one or reloads after a retirement, and a side write lands at its address one edge later. The cycle-exact latency, the arrival order under contention, the WAIT given to a same-cycle arrival, the forfeit of an absent head and the side-port priority on a shared word can only be shown by the bench scenarios. The bench follows each of these through the grant bits and the viewed line contents.

// File: rtl/fcfs_mem_pkg.sv
package fcfs_mem_pkg;

  localparam int WPL = 4;

  function automatic int line_of(input int addr);
    return addr / WPL;
  endfunction

  function automatic int word_of(input int addr);
    return addr % WPL;
  endfunction

  function automatic int flat_index(input int line, input int word);
    return line * WPL + word;
  endfunction

endpackage

// File: rtl/fcfs_order_queue.sv
module fcfs_order_queue #(
  parameter  int NREQ = 3,
  localparam int IDW  = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int CW   = $clog2(NREQ + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] present,
  input  logic            retire,
  output logic [IDW-1:0]  head_id,
  output logic            head_valid,
  output logic [NREQ-1:0] arrive
);

  logic [IDW-1:0]  slot_q  [NREQ];
  logic [CW-1:0]   cnt_q;
  logic [NREQ-1:0] queued_q;
  logic [IDW-1:0]  ext_ids [NREQ];
  logic [CW-1:0]   ext_cnt;
  logic [NREQ-1:0] head_mask;

  assign arrive = present & ~queued_q;

  // Existing entries first, then this cycle's newcomers in ascending number.
  always_comb begin
    int n;
    n = int'(cnt_q);
    ext_ids = slot_q;
    for (int i = 0; i < NREQ; i++) begin
      if (arrive[i]) begin
        if (n < NREQ) ext_ids[n] = IDW'(i);
        n = n + 1;
      end
    end
    ext_cnt = CW'(n);
  end

  assign head_id    = ext_ids[0];
  assign head_valid = (ext_cnt != '0);
  assign head_mask  = NREQ'(1) << head_id;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      queued_q <= '0;
      for (int k = 0; k < NREQ; k++) slot_q[k] <= '0;
    end else if (retire) begin
      for (int k = 0; k < NREQ - 1; k++) slot_q[k] <= ext_ids[k+1];
      slot_q[NREQ-1] <= '0;
      cnt_q    <= ext_cnt - 1'b1;
      queued_q <= (queued_q | arrive) & ~head_mask;
    end else begin
      slot_q   <= ext_ids;
      cnt_q    <= ext_cnt;
      queued_q <= queued_q | arrive;
    end
  end

  // R4: one flag per queued entry, so no client can occupy two slots.
  assert_flags_match_count_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(queued_q) == int'(cnt_q));

  assert_queue_bound_R4: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= NREQ);

endmodule

// File: rtl/fcfs_wait_counter.sv
module fcfs_wait_counter #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] delay_cfg,
  input  logic          active,
  output logic          at_zero
);

  logic [DW-1:0] cnt_q;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= delay_cfg;
    else if (active) begin
      if (at_zero)      cnt_q <= delay_cfg;
      else              cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_wait_decrements_R7: assert property (@(posedge clk) disable iff (rst)
    (active && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_wait_reloads_R7: assert property (@(posedge clk) disable iff (rst)
    (active && cnt_q == '0) |=> (cnt_q == $past(delay_cfg)));

  assert_wait_holds_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(cnt_q));

endmodule

// File: rtl/fcfs_word_array.sv
module fcfs_word_array
  import fcfs_mem_pkg::*;
#(
  parameter  int W     = 32,
  parameter  int LINES = 4,
  localparam int NW    = LINES * WPL,
  localparam int AW    = $clog2(NW),
  localparam int LW    = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_we,
  input  logic [AW-1:0]    q_addr,
  input  logic [W-1:0]     q_data,
  input  logic             s_we,
  input  logic [AW-1:0]    s_addr,
  input  logic [W-1:0]     s_data,
  input  logic [LW-1:0]    view_line,
  output logic [WPL*W-1:0] view_data
);

  logic [W-1:0] word_q [NW];

  // Side write is issued last so it wins on a shared word (R11).
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NW; k++) word_q[k] <= '0;
    end else begin
      if (q_we)
        word_q[flat_index(line_of(int'(q_addr)), word_of(int'(q_addr)))] <= q_data;
      if (s_we)
        word_q[flat_index(line_of(int'(s_addr)), word_of(int'(s_addr)))] <= s_data;
    end
  end

  for (genvar g = 0; g < WPL; g++) begin : g_view
    assign view_data[g*W +: W] = word_q[flat_index(int'(view_line), g)];
  end

  assert_side_lands_R3: assert property (@(posedge clk) disable iff (rst)
    s_we |=> (word_q[int'($past(s_addr))] == $past(s_data)));

endmodule

// File: rtl/fcfs_delay_mem.sv
module fcfs_delay_mem
  import fcfs_mem_pkg::*;
#(
  parameter  int W     = 32,
  parameter  int NREQ  = 3,
  parameter  int LINES = 4,
  parameter  int DW    = 4,
  localparam int AW    = $clog2(LINES * WPL),
  localparam int LW    = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int IDW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DW-1:0]      delay_cfg,
  input  logic [NREQ-1:0]    req_valid,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ*W-1:0]  req_data,
  output logic [NREQ-1:0]    req_ok,
  input  logic               side_valid,
  input  logic [AW-1:0]      side_addr,
  input  logic [W-1:0]       side_data,
  output logic               side_ok,
  input  logic [LW-1:0]      view_line,
  output logic [WPL*W-1:0]   view_data
);

  logic [IDW-1:0]  head_id;
  logic            head_valid;
  logic [NREQ-1:0] arrive_vec;
  logic            wait_zero;
  logic            retire_evt;
  logic            complete_evt;
  logic [AW-1:0]   wr_addr;
  logic [W-1:0]    wr_data;

  fcfs_order_queue #(.NREQ(NREQ)) order_i (
    .clk        (clk),
    .rst        (rst),
    .present    (req_valid),
    .retire     (retire_evt),
    .head_id    (head_id),
    .head_valid (head_valid),
    .arrive     (arrive_vec)
  );

  fcfs_wait_counter #(.DW(DW)) wait_i (
    .clk       (clk),
    .rst       (rst),
    .delay_cfg (delay_cfg),
    .active    (head_valid),
    .at_zero   (wait_zero)
  );

  assign retire_evt   = head_valid && wait_zero;
  assign complete_evt = retire_evt && req_valid[head_id];
  assign wr_addr      = req_addr[int'(head_id)*AW +: AW];
  assign wr_data      = req_data[int'(head_id)*W +: W];
  assign side_ok      = side_valid;

  for (genvar g = 0; g < NREQ; g++) begin : g_grant
    assign req_ok[g] = complete_evt && (head_id == IDW'(g));
  end

  fcfs_word_array #(.W(W), .LINES(LINES)) array_i (
    .clk       (clk),
    .rst       (rst),
    .q_we      (complete_evt),
    .q_addr    (wr_addr),
    .q_data    (wr_data),
    .s_we      (side_valid),
    .s_addr    (side_addr),
    .s_data    (side_data),
    .view_line (view_line),
    .view_data (view_data)
  );

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ok));

  // R5: a grant goes only to a client that is presenting.
  assert_grant_presented_R5: assert property (@(posedge clk) disable iff (rst)
    (req_ok & ~req_valid) == '0);

  // R10: an absent head is retired without any grant.
  assert_forfeit_no_grant_R10: assert property (@(posedge clk) disable iff (rst)
    (retire_evt && !complete_evt) |-> (req_ok == '0));

endmodule

// File: tb/fcfs_delay_mem_tb_top.sv
module fcfs_delay_mem_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W     = 32;
  localparam int NREQ  = 3;
  localparam int LINES = 4;
  localparam int DW    = 4;
  localparam int AW    = 4;
  localparam int LW    = 2;

  typedef struct {
    int              kind;
    string           tag;
    logic [4*W-1:0]  exp;
  } item_t;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [DW-1:0]      delay_cfg = '0;
  logic [NREQ-1:0]    req_valid = '0;
  logic [NREQ*AW-1:0] req_addr = '0;
  logic [NREQ*W-1:0]  req_data = '0;
  logic [NREQ-1:0]    req_ok;
  logic               side_valid = 1'b0;
  logic [AW-1:0]      side_addr = '0;
  logic [W-1:0]       side_data = '0;
  logic               side_ok;
  logic [LW-1:0]      view_line = '0;
  logic [4*W-1:0]     view_data;

  item_t      sb_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  logic [W-1:0] shadow [LINES*4];

  always #(CLK_PERIOD/2) clk = ~clk;

  fcfs_delay_mem #(.W(W), .NREQ(NREQ), .LINES(LINES), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .delay_cfg(delay_cfg),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data), .req_ok(req_ok),
    .side_valid(side_valid), .side_addr(side_addr), .side_data(side_data), .side_ok(side_ok),
    .view_line(view_line), .view_data(view_data)
  );

  task automatic set_req(input int i, input int addr, input logic [W-1:0] data);
    req_addr[i*AW +: AW] = AW'(addr);
    req_data[i*W +: W]   = data;
  endtask

  task automatic do_reset(input int d);
    @(negedge clk);
    rst = 1'b1; delay_cfg = DW'(d); req_valid = '0; side_valid = 1'b0;
    for (int k = 0; k < LINES*4; k++) shadow[k] = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Driver: one cycle of stimulus, expectations pushed to the scoreboard.
  task automatic step(input logic [NREQ-1:0] v, input logic [NREQ-1:0] eok,
                      input logic sv, input int vline, input string tag);
    item_t it;
    @(negedge clk);
    req_valid = v; side_valid = sv; view_line = LW'(vline);
    it.tag = tag;
    it.kind = 0; it.exp = '0; it.exp[NREQ-1:0] = eok; sb_q.push_back(it);
    it.kind = 1; it.exp = '0; it.exp[0] = sv;         sb_q.push_back(it);
    it.kind = 2; it.exp = '0;
    for (int k = 0; k < 4; k++) it.exp[k*W +: W] = shadow[vline*4 + k];
    sb_q.push_back(it);
    for (int i = 0; i < NREQ; i++)
      if (eok[i]) shadow[int'(req_addr[i*AW +: AW])] = req_data[i*W +: W];
    if (sv) shadow[int'(side_addr)] = side_data;
  endtask

  // Monitor: compares a quarter period after the drive, well before the edge.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        case (it.kind)
          0: if (req_ok !== it.exp[NREQ-1:0]) begin
               n_bad++;
               $display("FAIL %s: req_ok got %b exp %b", it.tag, req_ok, it.exp[NREQ-1:0]);
             end
          1: if (side_ok !== it.exp[0]) begin
               n_bad++;
               $display("FAIL %s: side_ok got %b exp %b", it.tag, side_ok, it.exp[0]);
             end
          default: if (view_data !== it.exp) begin
               n_bad++;
               $display("FAIL %s: view got %h exp %h", it.tag, view_data, it.exp);
             end
        endcase
      end
    end
  end

  initial begin
    #(CLK_PERIOD*50000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1, R6: delay 3, single client
    do_reset(3);
    set_req(0, 0, 32'hA000_0001);
    set_req(1, 1, 32'hB000_0002);
    set_req(2, 2, 32'hC000_0003);
    step(3'b000, 3'b000, 1'b0, 0, "R1 reset state");
    for (int c = 0; c < 3; c++) step(3'b001, 3'b000, 1'b0, 0, "R6 wait phase");
    step(3'b001, 3'b001, 1'b0, 0, "R6 ok after delay");
    step(3'b000, 3'b000, 1'b0, 0, "R5 write visible");

    // R8: same-cycle arrival during completion
    for (int c = 0; c < 3; c++) step(3'b001, 3'b000, 1'b0, 0, "R8 head waiting");
    step(3'b011, 3'b001, 1'b0, 0, "R8 head done, newcomer waits");
    for (int c = 0; c < 3; c++) step(3'b010, 3'b000, 1'b0, 0, "R8 full delay again");
    step(3'b010, 3'b010, 1'b0, 0, "R8 newcomer ok");
    step(3'b000, 3'b000, 1'b0, 0, "R5 view after R8");

    // R9, R4: delay 2, simultaneous arrivals and a later joiner
    do_reset(2);
    set_req(0, 0, 32'h1111_0000);
    set_req(1, 1, 32'h2222_0001);
    set_req(2, 3, 32'h3333_0003);
    step(3'b011, 3'b000, 1'b0, 0, "R4 tie order c0");
    step(3'b011, 3'b000, 1'b0, 0, "R4 tie order c1");
    step(3'b011, 3'b001, 1'b0, 0, "R4 lower number first");
    step(3'b110, 3'b000, 1'b0, 0, "R9 c3");
    step(3'b110, 3'b000, 1'b0, 0, "R9 c4");
    step(3'b110, 3'b010, 1'b0, 0, "R9 second ok");
    step(3'b100, 3'b000, 1'b0, 0, "R9 c6");
    step(3'b100, 3'b000, 1'b0, 0, "R9 c7");
    step(3'b100, 3'b100, 1'b0, 0, "R9 third ok");
    step(3'b000, 3'b000, 1'b0, 0, "R2 line 0 words");

    // R9, R4: delay 1, higher-numbered earlier arrival beats lower number
    do_reset(1);
    set_req(0, 0, 32'h0A0A_0A0A);
    set_req(1, 1, 32'h0B0B_0B0B);
    set_req(2, 2, 32'h0C0C_0C0C);
    step(3'b100, 3'b000, 1'b0, 0, "R9 cache first");
    step(3'b110, 3'b100, 1'b0, 0, "R9 cache ok");
    step(3'b011, 3'b000, 1'b0, 0, "R9 fetch ahead of mem");
    step(3'b011, 3'b010, 1'b0, 0, "R9 fetch ok");
    step(3'b001, 3'b000, 1'b0, 0, "R9 mem waits");
    step(3'b001, 3'b001, 1'b0, 0, "R9 mem ok");
    step(3'b010, 3'b000, 1'b0, 0, "R4 no duplicate entry");
    step(3'b010, 3'b010, 1'b0, 0, "R4 fetch served next");
    step(3'b000, 3'b000, 1'b0, 0, "R2 view after order test");

    // R10: absent head forfeits its turn
    do_reset(2);
    set_req(0, 6, 32'hDEAD_0006);
    set_req(1, 5, 32'hBEEF_0005);
    step(3'b011, 3'b000, 1'b0, 1, "R10 c0");
    step(3'b010, 3'b000, 1'b0, 1, "R10 c1");
    step(3'b010, 3'b000, 1'b0, 1, "R10 absent head retired");
    step(3'b010, 3'b000, 1'b0, 1, "R10 c3");
    step(3'b010, 3'b000, 1'b0, 1, "R10 c4");
    step(3'b010, 3'b010, 1'b0, 1, "R10 fetch ok");
    step(3'b001, 3'b000, 1'b0, 1, "R10 mem requeued");
    step(3'b001, 3'b000, 1'b0, 1, "R10 mem c7");
    step(3'b001, 3'b001, 1'b0, 1, "R10 mem ok");
    step(3'b000, 3'b000, 1'b0, 1, "R2 line 1 words");

    // R3, R11, R2: side port
    do_reset(3);
    set_req(0, 14, 32'h5A5A_000E);
    side_addr = AW'(5); side_data = 32'h51DE_0005;
    step(3'b001, 3'b000, 1'b0, 3, "R3 c0");
    step(3'b001, 3'b000, 1'b1, 1, "R3 side ok while queued waits");
    step(3'b001, 3'b000, 1'b0, 1, "R3 side data visible");
    side_addr = AW'(14); side_data = 32'h51DE_000E;
    step(3'b001, 3'b001, 1'b1, 3, "R11 same word both write");
    step(3'b000, 3'b000, 1'b0, 3, "R11 side value kept");

    // R6: zero delay
    do_reset(0);
    set_req(0, 7, 32'h0000_7777);
    step(3'b001, 3'b001, 1'b0, 1, "R6 zero delay ok at once");
    step(3'b000, 3'b000, 1'b0, 1, "R6 zero delay written");

    @(negedge clk);
    req_valid = '0; side_valid = 1'b0;
    #(CLK_PERIOD/2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule